// File: doc/BRIEF.md
# Peripheral Idle/Wake Trap Monitor

This block follows the power state of three legacy peripherals, a floppy disk controller and two serial ports. Each peripheral is either sleeping or working. Any sign of activity on a peripheral's own event inputs moves it to working. After a programmable number of quiet clock cycles it returns to sleeping. Power-management logic elsewhere reads the state of all three peripherals as one byte through a small register port. That port also holds the 16-bit idle timeout.

The floppy controller wakes on a host access, an interrupt request or a DMA acknowledge. It also wakes on a write to its output control register that sets at least one motor-enable bit. A serial port wakes on a host access, an interrupt request, the start of a received start bit or the start of a transmitted start bit. It also wakes on either edge of any of its modem-control input lines. Edges are found by comparing each line with its value in the previous cycle. All event inputs are sampled on the rising clock edge and are taken as synchronous to the clock.

Each peripheral has its own idle counter. A wake event loads the counter from the shared timeout. A wake event always wins over expiry in the same cycle. A timeout of zero keeps a woken peripheral working.

Top module: `pwr_trap_monitor`

## Requirements
- R1: After reset, all three peripherals are sleeping, the trap status reads 0x00 and the timeout reads 0x0000.
- R2: Status byte layout (register address 0): bit 2 is the floppy controller, bit 1 is serial port A and bit 0 is serial port B. A bit is 1 while its peripheral is working. Bits 7..3 always read 0.
- R3: A floppy host access, interrupt request or DMA acknowledge that is high at a clock edge sets status bit 2 from that edge.
- R4: A write strobe to the floppy output control register wakes the floppy controller only when its motor-enable field is non-zero. With the field all zero, the strobe has no effect.
- R5: A host access or an interrupt request on a serial port, high at a clock edge, sets that port's status bit from that edge.
- R6: A receive start-bit event or a transmit start-bit event on a serial port sets that port's status bit.
- R7: A rising or a falling transition on any modem-control line of a serial port wakes that port at the edge where the new value is first sampled. A line that holds its level causes no wake.
- R8: With timeout T > 0, a peripheral stays working for exactly T cycles after the last cycle with a wake event. It reads sleeping from the next edge on.
- R9: With timeout zero, a working peripheral stays working indefinitely.
- R10: A wake event in the cycle where the idle count would expire keeps the peripheral working and reloads the full timeout.
- R11: The low timeout byte is at address 1 and the high byte at address 2. Both are read/write. Writes to addresses 0 and 3 are ignored, and address 3 reads 0x00.
- R12: An event on one peripheral never changes the status bit of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data (combinational on bus_addr) |
| fdc_access | input | 1 | Floppy host access strobe |
| fdc_irq | input | 1 | Floppy interrupt request |
| fdc_dack | input | 1 | Floppy DMA acknowledge |
| fdc_ctl_wr | input | 1 | Write strobe of the floppy output control register |
| fdc_motor_en | input | MOTOR_W | Motor-enable field of that write |
| sera_access | input | 1 | Serial A host access strobe |
| sera_irq | input | 1 | Serial A interrupt request |
| sera_rx_start | input | 1 | Serial A receiver start-bit detected |
| sera_tx_start | input | 1 | Serial A transmit shifter starts a start bit |
| sera_modem | input | MDM_W | Serial A modem-control inputs, synchronized |
| serb_access | input | 1 | Serial B host access strobe |
| serb_irq | input | 1 | Serial B interrupt request |
| serb_rx_start | input | 1 | Serial B receiver start-bit detected |
| serb_tx_start | input | 1 | Serial B transmit shifter starts a start bit |
| serb_modem | input | MDM_W | Serial B modem-control inputs, synchronized |

## Verification
The assertions check these rules on every cycle:
- The reserved status bits stay zero.
- A combined wake event sets its bit at the next edge, and a sleeping peripheral with no event stays asleep.
- A zero timeout never lets a bit fall, and a bit never falls right after a wake cycle.
- A motor-enable write or a modem-line transition on a port reaches that port's bit.

Three things need the bench's directed scenarios, because they depend on exact counts and decoding:
- the exact length of the working window for a given timeout, and the reload when a wake event arrives on the expiry cycle;
- the fact that a steady modem level or a zero motor field causes no wake;
- the register map, including the ignored writes.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NUM_DEV  = 3;
  localparam int IDX_SERB = 0;
  localparam int IDX_SERA = 1;
  localparam int IDX_FDC  = 2;
  localparam int NUM_SER  = 2;
  localparam int REG_AW   = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_STATUS = 2'd0,
    RA_TMO_LO = 2'd1,
    RA_TMO_HI = 2'd2,
    RA_SPARE  = 2'd3
  } reg_addr_e;

  // floppy wake: any of the direct events, or a control write with motors on
  function automatic logic fdc_wake(input logic access, input logic irq,
                                    input logic dack, input logic ctl_wr,
                                    input logic motor_any);
    return access | irq | dack | (ctl_wr & motor_any);
  endfunction

  // serial wake: direct events plus any modem-line transition
  function automatic logic ser_wake(input logic access, input logic irq,
                                    input logic rx_start, input logic tx_start,
                                    input logic mdm_edge);
    return access | irq | rx_start | tx_start | mdm_edge;
  endfunction

  // the count is on its last working cycle when it holds one or zero
  function automatic logic last_tick(input logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction
endpackage

// File: rtl/line_edge.sv
module line_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  output logic [W-1:0] edge_vec,
  output logic         edge_any
);
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lines;
      primed_q <= 1'b1;
    end
  end

  // no compare until a first sample is held, so a high line at reset is no edge
  assign edge_vec = primed_q ? (lines ^ prev_q) : '0;
  assign edge_any = |edge_vec;
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake,
  input  logic [CNT_W-1:0] tmo,
  output logic             working,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             tmo_on;

  assign tmo_on = (tmo != '0);
  // wake has priority: expiry only when no event is present this cycle
  assign expire = working & ~wake & tmo_on & last_tick(32'(cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      working <= 1'b0;
      cnt_q   <= '0;
    end else if (wake) begin
      working <= 1'b1;
      cnt_q   <= tmo;
    end else if (expire) begin
      working <= 1'b0;
      cnt_q   <= '0;
    end else if (working && tmo_on) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trap_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter logic [2*DATA_W-1:0] TMO_RST = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REG_AW-1:0]   addr,
  input  logic                wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_DEV-1:0]  work_vec,
  output logic [DATA_W-1:0]   rdata,
  output logic [2*DATA_W-1:0] tmo,
  output logic [DATA_W-1:0]   status
);
  logic [DATA_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= TMO_RST[DATA_W-1:0];
      hi_q <= TMO_RST[2*DATA_W-1:DATA_W];
    end else if (wr) begin
      if (addr == RA_TMO_LO) lo_q <= wdata;
      if (addr == RA_TMO_HI) hi_q <= wdata;
    end
  end

  assign tmo = {hi_q, lo_q};

  always_comb begin
    status = '0;
    status[NUM_DEV-1:0] = work_vec;
  end

  always_comb begin
    case (reg_addr_e'(addr))
      RA_STATUS: rdata = status;
      RA_TMO_LO: rdata = lo_q;
      RA_TMO_HI: rdata = hi_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwr_trap_monitor.sv
module pwr_trap_monitor
  import trap_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter int                MOTOR_W = 4,
  parameter int                MDM_W   = 4,
  parameter logic [2*DATA_W-1:0] TMO_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               fdc_access,
  input  logic               fdc_irq,
  input  logic               fdc_dack,
  input  logic               fdc_ctl_wr,
  input  logic [MOTOR_W-1:0] fdc_motor_en,
  input  logic               sera_access,
  input  logic               sera_irq,
  input  logic               sera_rx_start,
  input  logic               sera_tx_start,
  input  logic [MDM_W-1:0]   sera_modem,
  input  logic               serb_access,
  input  logic               serb_irq,
  input  logic               serb_rx_start,
  input  logic               serb_tx_start,
  input  logic [MDM_W-1:0]   serb_modem
);
  localparam int TMO_W = 2 * DATA_W;

  // named internal events, also used by the bound checker
  logic [NUM_DEV-1:0] wake_vec;
  logic [NUM_DEV-1:0] work_vec;
  logic [NUM_DEV-1:0] expire_vec;
  logic [NUM_SER-1:0] mdm_edge;
  logic [TMO_W-1:0]   tmo_val;
  logic [DATA_W-1:0]  status_byte;
  logic               motor_any;

  // serial inputs gathered per port; index 0 is port B, 1 is port A
  logic [NUM_SER-1:0] s_access, s_irq, s_rx, s_tx;
  logic [MDM_W-1:0]   s_modem [NUM_SER];

  assign s_access = {sera_access,   serb_access};
  assign s_irq    = {sera_irq,      serb_irq};
  assign s_rx     = {sera_rx_start, serb_rx_start};
  assign s_tx     = {sera_tx_start, serb_tx_start};
  assign s_modem[0] = serb_modem;
  assign s_modem[1] = sera_modem;

  assign motor_any = |fdc_motor_en;
  assign wake_vec[IDX_FDC] = fdc_wake(fdc_access, fdc_irq, fdc_dack,
                                      fdc_ctl_wr, motor_any);

  for (genvar p = 0; p < NUM_SER; p++) begin : g_ser
    logic [MDM_W-1:0] edge_bits;
    line_edge #(.W(MDM_W)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines    (s_modem[p]),
      .edge_vec (edge_bits),
      .edge_any (mdm_edge[p])
    );
    // port index p maps onto status bit p (B -> 0, A -> 1)
    assign wake_vec[p] = ser_wake(s_access[p], s_irq[p], s_rx[p], s_tx[p],
                                  mdm_edge[p]);
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    trap_unit #(.CNT_W(TMO_W)) u_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .wake    (wake_vec[d]),
      .tmo     (tmo_val),
      .working (work_vec[d]),
      .expire  (expire_vec[d])
    );
  end

  trap_regs #(.DATA_W(DATA_W), .TMO_RST(TMO_RST)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .work_vec (work_vec),
    .rdata    (bus_rdata),
    .tmo      (tmo_val),
    .status   (status_byte)
  );
endmodule

// File: rtl/trap_monitor_chk.sv
module trap_monitor_chk
  import trap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TMO_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DATA_W-1:0]  status_byte,
  input logic [NUM_DEV-1:0] wake_vec,
  input logic [NUM_SER-1:0] mdm_edge,
  input logic [TMO_W-1:0]   tmo_val,
  input logic               fdc_ctl_wr,
  input logic               motor_any
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[DATA_W-1:NUM_DEV] == '0);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    // R3 R5 R6
    wake_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_vec[d] |=> status_byte[d]);
    // R12
    no_spont_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_byte[d] && !wake_vec[d]) |=> !status_byte[d]);
    // R9
    zero_tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_byte[d] && tmo_val == '0) |=> status_byte[d]);
    // R10
    fall_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_byte[d]) |-> !$past(wake_vec[d]));
  end

  // R4
  motor_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fdc_ctl_wr && motor_any) |=> status_byte[IDX_FDC]);

  // R7
  mdm_a_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdm_edge[1] |=> status_byte[IDX_SERA]);

  // R7
  mdm_b_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdm_edge[0] |=> status_byte[IDX_SERB]);
endmodule

bind pwr_trap_monitor trap_monitor_chk #(.DATA_W(DATA_W), .TMO_W(2*DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_byte (status_byte),
  .wake_vec    (wake_vec),
  .mdm_edge    (mdm_edge),
  .tmo_val     (tmo_val),
  .fdc_ctl_wr  (fdc_ctl_wr),
  .motor_any   (motor_any)
);

// File: tb/pwr_trap_monitor_tb.sv
module pwr_trap_monitor_tb;
  localparam int CLK_NS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       fdc_access = 0, fdc_irq = 0, fdc_dack = 0, fdc_ctl_wr = 0;
  logic [3:0] fdc_motor_en = 4'd0;
  logic       sera_access = 0, sera_irq = 0, sera_rx_start = 0, sera_tx_start = 0;
  logic [3:0] sera_modem = 4'd0;
  logic       serb_access = 0, serb_irq = 0, serb_rx_start = 0, serb_tx_start = 0;
  logic [3:0] serb_modem = 4'd0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  pwr_trap_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fdc_access(fdc_access), .fdc_irq(fdc_irq), .fdc_dack(fdc_dack),
    .fdc_ctl_wr(fdc_ctl_wr), .fdc_motor_en(fdc_motor_en),
    .sera_access(sera_access), .sera_irq(sera_irq),
    .sera_rx_start(sera_rx_start), .sera_tx_start(sera_tx_start),
    .sera_modem(sera_modem),
    .serb_access(serb_access), .serb_irq(serb_irq),
    .serb_rx_start(serb_rx_start), .serb_tx_start(serb_tx_start),
    .serb_modem(serb_modem)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
    bus_addr = 2'd0;
  endtask

  task automatic chk_status(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(2'd0, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic set_tmo(input logic [15:0] t);
    wr(2'd1, t[7:0]);
    wr(2'd2, t[15:8]);
  endtask

  // timeout of one ends every working window within a couple of edges
  task automatic go_sleep(input string req);
    set_tmo(16'd1);
    repeat (3) @(negedge clk);
    chk_status(req, 8'h00);
  endtask

  // drive one event source for a single cycle, then check the status
  task automatic pulse(input int dev, input int src, input logic [7:0] exp, input string req);
    @(negedge clk);
    case (dev)
      2: case (src) 0: fdc_access = 1; 1: fdc_irq = 1; default: fdc_dack = 1; endcase
      1: case (src) 0: sera_access = 1; 1: sera_irq = 1; 2: sera_rx_start = 1; default: sera_tx_start = 1; endcase
      default: case (src) 0: serb_access = 1; 1: serb_irq = 1; 2: serb_rx_start = 1; default: serb_tx_start = 1; endcase
    endcase
    @(negedge clk);
    fdc_access = 0; fdc_irq = 0; fdc_dack = 0;
    sera_access = 0; sera_irq = 0; sera_rx_start = 0; sera_tx_start = 0;
    serb_access = 0; serb_irq = 0; serb_rx_start = 0; serb_tx_start = 0;
    chk_status(req, exp);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk_status("R1 status", 8'h00);
    rd(2'd1, v); chk("R1 tmo lo", v, 8'h00);
    rd(2'd2, v); chk("R1 tmo hi", v, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(2'd1, 8'h34);
    wr(2'd2, 8'h12);
    rd(2'd1, v); chk("R11 tmo lo readback", v, 8'h34);
    rd(2'd2, v); chk("R11 tmo hi readback", v, 8'h12);
    wr(2'd0, 8'hFF);
    chk_status("R11 status write ignored", 8'h00);
    wr(2'd3, 8'hA5);
    rd(2'd3, v); chk("R11 spare reads zero", v, 8'h00);
    rd(2'd1, v); chk("R11 lo unchanged", v, 8'h34);
    rd(2'd2, v); chk("R11 hi unchanged", v, 8'h12);
  endtask

  task automatic t_fdc_sources;
    for (int s = 0; s < 3; s++) begin
      set_tmo(16'd0);
      pulse(2, s, 8'h04, "R3 fdc source, R12");
      go_sleep("R8 fdc back to sleep");
    end
  endtask

  task automatic t_motor;
    set_tmo(16'd0);
    @(negedge clk); fdc_ctl_wr = 1; fdc_motor_en = 4'b0000;
    @(negedge clk); fdc_ctl_wr = 0;
    chk_status("R4 zero motor field ignored", 8'h00);
    @(negedge clk); fdc_ctl_wr = 1; fdc_motor_en = 4'b0100;
    @(negedge clk); fdc_ctl_wr = 0; fdc_motor_en = 4'b0000;
    chk_status("R4 motor enable wakes", 8'h04);
    go_sleep("R8 after motor");
  endtask

  task automatic t_serial_sources;
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 4; s++) begin
        set_tmo(16'd0);
        pulse(p, s, (p == 1) ? 8'h02 : 8'h01,
              (s < 2) ? "R5 serial access/irq, R12" : "R6 serial start bit, R12");
        go_sleep("R8 serial back to sleep");
      end
    end
  endtask

  task automatic t_modem;
    set_tmo(16'd0);
    @(negedge clk); sera_modem[1] = 1'b1;
    @(negedge clk);
    chk_status("R7 modem A rising", 8'h02);
    go_sleep("R8 after modem A rise");
    repeat (4) @(negedge clk);
    chk_status("R7 steady modem level no wake", 8'h00);
    set_tmo(16'd0);
    @(negedge clk); sera_modem[1] = 1'b0;
    @(negedge clk);
    chk_status("R7 modem A falling", 8'h02);
    go_sleep("R8 after modem A fall");
    set_tmo(16'd0);
    @(negedge clk); serb_modem[3] = 1'b1;
    @(negedge clk);
    chk_status("R7 modem B rising, R12", 8'h01);
    go_sleep("R8 after modem B");
    @(negedge clk); serb_modem[3] = 1'b0;
    @(negedge clk);
    set_tmo(16'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_expiry;
    set_tmo(16'd5);
    pulse(2, 0, 8'h04, "R8 woken");
    repeat (4) @(negedge clk);
    chk_status("R8 still working at cycle 5", 8'h04);
    @(negedge clk);
    chk_status("R8 asleep after 5 cycles", 8'h00);
  endtask

  task automatic t_priority;
    set_tmo(16'd5);
    pulse(2, 0, 8'h04, "R10 woken");
    repeat (3) @(negedge clk);
    @(negedge clk); fdc_irq = 1;
    @(negedge clk); fdc_irq = 0;
    chk_status("R10 wake beats expiry", 8'h04);
    repeat (4) @(negedge clk);
    chk_status("R10 full reload", 8'h04);
    @(negedge clk);
    chk_status("R10 sleeps after reload", 8'h00);
  endtask

  task automatic t_zero_hold;
    set_tmo(16'd0);
    pulse(1, 1, 8'h02, "R9 woken");
    repeat (50) @(negedge clk);
    chk_status("R9 zero timeout holds", 8'h02);
    go_sleep("R8 after hold");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_fdc_sources();
    t_motor();
    t_serial_sources();
    t_modem();
    t_expiry();
    t_priority();
    t_zero_hold();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule